// File: doc/BRIEF.md
# Strided Modulo-N Memory Tester

This block is a self-test engine for a word-wide synchronous RAM. It runs a stride-based interaction test that does not rely on the order in which writes reach the array. A 32-bit pseudo-random word is the test pattern. For each of twenty lane offsets, the engine writes that word into one lane of the address window, where a lane is every twentieth word. It then covers every other word of the window with the inverted word, in one or more sweeps. Only after all those writes does it read the lane back and compare each word.

Software or a sequencer sets the window bounds and the number of inverted sweeps, then pulses `start`. The engine drives the RAM port with one access per cycle. It raises an event carrying the address, the expected word and the word read for every lane word that comes back wrong. It pulses `done` when the last lane of the last offset has been compared. The pattern is drawn once per test and stays the same across all twenty offsets.

Top module: `stride_mem_tester`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `err_valid`, `mem_en` and `mem_we` are all 0.
- R2: A `start` pulse seen while `busy` is 0 latches `cfg_base`, `cfg_last` and `cfg_reps`. It also advances the pattern generator one step. The generator is a 32-bit right-shifting register: the next state is `s>>1`, XOR-ed with 0x80200003 when bit 0 of `s` is 1. Its reset state is 0x1D872B41, and the pattern is the new state. `busy` is 1 in the next cycle. A `start` while `busy` is 1 is ignored.
- R3: For lane offset k, the engine writes the pattern exactly once to every address base+k+20·j that is no greater than last. It writes these addresses in ascending order and issues no other pattern writes.
- R4: After the lane writes for offset k, the engine writes the inverted pattern to every address in [base, last] that is not in lane k, in ascending order. A position counter that wraps after 19 picks out the lane. This sweep runs `cfg_reps` times, and a value of 0 counts as 1.
- R5: After the inverted sweeps, the engine reads lane k in ascending order. A word that differs from the pattern raises `err_valid` for one cycle, two cycles after the read was issued. `err_addr`, `err_exp` and `err_obs` give the address, the pattern and the word read.
- R6: The offsets run 0 to 19 in order, with one pattern for the whole test. At the end, lane 19 holds the pattern and the rest of the window holds its inverse.
- R7: `done` is a one-cycle pulse in the cycle after the data of the final lane read of offset 19 returns. `busy` is 0 in that cycle. An error event for that final read falls in the same cycle as `done`. A full test takes the sum over k of (2·L_k + 2 + N·reps) cycles from the start edge, where L_k is the lane size and N is the window size.
- R8: No memory access falls outside [base, last].
- R9: A start with `cfg_last` < `cfg_base` performs no memory access and pulses `done` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test (taken only when idle) |
| cfg_base | input | ADDR_W | First word of the window |
| cfg_last | input | ADDR_W | Last word of the window (inclusive) |
| cfg_reps | input | REP_W | Number of inverted sweeps per offset (0 means 1) |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write when 1, read when 0 |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, valid the cycle after a read |
| err_valid | output | 1 | Mismatch event strobe |
| err_addr | output | ADDR_W | Address of the failing word |
| err_exp | output | 32 | Expected word |
| err_obs | output | 32 | Word read back |

## Verification
The compare of the last lane read of offset 19 and the end-of-test pulse can land in the same cycle. The comparison runs one cycle behind the read, and the state machine retires the test in the cycle that comparison completes. The bench places a stuck bit at the highest lane-19 address of a window, so that this final read is the one that fails. It then requires `err_valid` and `done` to be high at the same sample, with `busy` low and the event naming that address. The bench also counts the cycles to `done` and compares them with the count predicted from the window size and the number of sweeps.

// File: rtl/stm_pkg.sv
package stm_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LANE,
        ST_FILL,
        ST_CHECK
    } stm_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] expd;
        logic [DATA_W-1:0] seen;
    } stm_pair_t;

    function automatic logic [DATA_W-1:0] lfsr_step(
        input logic [DATA_W-1:0] s,
        input logic [DATA_W-1:0] poly
    );
        return s[0] ? ((s >> 1) ^ poly) : (s >> 1);
    endfunction

endpackage

// File: rtl/stm_pattern_src.sv
module stm_pattern_src
    import stm_pkg::*;
#(
    parameter logic [DATA_W-1:0] SEED = 32'h1D87_2B41,
    parameter logic [DATA_W-1:0] POLY = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [DATA_W-1:0] pattern
);
    logic [DATA_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (advance) begin
            state_q <= lfsr_step(state_q, POLY);
        end
    end

    assign pattern = state_q;
endmodule

// File: rtl/stm_lane_counter.sv
module stm_lane_counter #(
    parameter int STRIDE = 20,
    localparam int OFF_W = $clog2(STRIDE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [OFF_W-1:0] phase
);
    localparam logic [OFF_W-1:0] WRAP_AT = OFF_W'(STRIDE - 1);

    logic [OFF_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (step) begin
            phase_q <= (phase_q == WRAP_AT) ? '0 : phase_q + 1'b1;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/stm_compare.sv
module stm_compare
    import stm_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issue,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] expect_word,
    input  logic [DATA_W-1:0] rdata,
    output logic              ev_valid,
    output logic [ADDR_W-1:0] ev_addr,
    output stm_pair_t         ev_pair
);
    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic              miss;

    assign miss = pend_q && (rdata != expect_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            addr_q   <= '0;
            ev_valid <= 1'b0;
            ev_addr  <= '0;
            ev_pair  <= '0;
        end else begin
            pend_q   <= rd_issue;
            addr_q   <= rd_addr;
            ev_valid <= miss;
            if (miss) begin
                ev_addr      <= addr_q;
                ev_pair.expd <= expect_word;
                ev_pair.seen <= rdata;
            end
        end
    end
endmodule

// File: rtl/stride_mem_tester.sv
module stride_mem_tester
    import stm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int REP_W  = 4,
    parameter int STRIDE = 20,
    parameter logic [DATA_W-1:0] SEED = 32'h1D87_2B41,
    parameter logic [DATA_W-1:0] POLY = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_last,
    input  logic [REP_W-1:0]  cfg_reps,
    output logic              busy,
    output logic              done,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_exp,
    output logic [DATA_W-1:0] err_obs
);
    localparam int OFF_W = $clog2(STRIDE);
    localparam logic [ADDR_W:0]  STEP_V   = (ADDR_W + 1)'(STRIDE);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(STRIDE - 1);
    localparam logic [REP_W-1:0] REP_ONE  = REP_W'(1);

    stm_state_e        state_q;
    logic [ADDR_W-1:0] base_q, last_q;
    logic [REP_W-1:0]  reps_q, rep_q;
    logic [OFF_W-1:0]  off_q;
    logic [ADDR_W:0]   cur_q;
    logic              done_q;

    logic [DATA_W-1:0] pattern;
    logic [OFF_W-1:0]  phase;
    logic              accept, in_range, fill_end, lane_hit, rd_issue;
    logic [ADDR_W:0]   base_x, off_x, off_nx_x;
    logic [OFF_W-1:0]  off_nx;
    stm_pair_t         ev_pair;

    assign accept   = start && (state_q == ST_IDLE);
    assign in_range = cur_q <= {1'b0, last_q};
    assign fill_end = (state_q == ST_FILL) && (cur_q[ADDR_W-1:0] == last_q);
    assign lane_hit = (phase == off_q);
    assign rd_issue = (state_q == ST_CHECK) && in_range;
    assign base_x   = {1'b0, base_q};
    assign off_x    = (ADDR_W + 1)'(off_q);
    assign off_nx   = off_q + 1'b1;
    assign off_nx_x = (ADDR_W + 1)'(off_nx);

    stm_pattern_src #(
        .SEED(SEED),
        .POLY(POLY)
    ) u_pattern (
        .clk    (clk),
        .rst    (rst),
        .advance(accept),
        .pattern(pattern)
    );

    stm_lane_counter #(
        .STRIDE(STRIDE)
    ) u_lane (
        .clk  (clk),
        .rst  (rst),
        .clear((state_q != ST_FILL) || fill_end),
        .step (state_q == ST_FILL),
        .phase(phase)
    );

    stm_compare #(
        .ADDR_W(ADDR_W)
    ) u_compare (
        .clk        (clk),
        .rst        (rst),
        .rd_issue   (rd_issue),
        .rd_addr    (cur_q[ADDR_W-1:0]),
        .expect_word(pattern),
        .rdata      (mem_rdata),
        .ev_valid   (err_valid),
        .ev_addr    (err_addr),
        .ev_pair    (ev_pair)
    );

    assign err_exp = ev_pair.expd;
    assign err_obs = ev_pair.seen;

    // Memory port: one access per cycle, driven from the sweep state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = pattern;
        mem_addr  = cur_q[ADDR_W-1:0];
        unique case (state_q)
            ST_LANE: begin
                mem_en = in_range;
                mem_we = in_range;
            end
            ST_FILL: begin
                mem_en    = !lane_hit;
                mem_we    = !lane_hit;
                mem_wdata = ~pattern;
            end
            ST_CHECK: begin
                mem_en = in_range;
            end
            default: begin
                mem_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            last_q  <= '0;
            reps_q  <= REP_ONE;
            rep_q   <= REP_ONE;
            off_q   <= '0;
            cur_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        base_q <= cfg_base;
                        last_q <= cfg_last;
                        reps_q <= (cfg_reps == '0) ? REP_ONE : cfg_reps;
                        off_q  <= '0;
                        cur_q  <= {1'b0, cfg_base};
                        if (cfg_last < cfg_base) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_LANE;
                        end
                    end
                end
                ST_LANE: begin
                    if (in_range) begin
                        cur_q <= cur_q + STEP_V;
                    end else begin
                        state_q <= ST_FILL;
                        cur_q   <= base_x;
                        rep_q   <= REP_ONE;
                    end
                end
                ST_FILL: begin
                    if (fill_end) begin
                        if (rep_q == reps_q) begin
                            state_q <= ST_CHECK;
                            cur_q   <= base_x + off_x;
                        end else begin
                            rep_q <= rep_q + 1'b1;
                            cur_q <= base_x;
                        end
                    end else begin
                        cur_q <= cur_q + 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (in_range) begin
                        cur_q <= cur_q + STEP_V;
                    end else if (off_q == OFF_LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        off_q   <= off_nx;
                        cur_q   <= base_x + off_nx_x;
                        state_q <= ST_LANE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
endmodule

// File: rtl/stm_tester_chk.sv
module stm_tester_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [ADDR_W-1:0] cfg_last,
    input logic              err_valid,
    input logic [ADDR_W-1:0] err_addr
);
    logic [ADDR_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '1;
        end else if (start && !busy) begin
            lo_q <= cfg_base;
            hi_q <= cfg_last;
        end
    end

    // R1
    idle_port_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_en);

    // R2
    start_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy || done));

    // R5
    err_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> $past(mem_en && !mem_we, 2));

    // R5
    err_addr_match_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_addr == $past(mem_addr, 2)));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R8
    addr_window_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (mem_addr >= lo_q && mem_addr <= hi_q));
endmodule

bind stride_mem_tester stm_tester_chk #(
    .ADDR_W(ADDR_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .cfg_base (cfg_base),
    .cfg_last (cfg_last),
    .err_valid(err_valid),
    .err_addr (err_addr)
);

// File: tb/test_stride_mem_tester.sv
`timescale 1ns/1ps
module test_stride_mem_tester;

    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [31:0] SEED_M = 32'h1D87_2B41;
    localparam logic [31:0] POLY_M = 32'h8020_0003;
    localparam int RUN_LIMIT = 60000;

    typedef struct packed {
        logic [7:0] base;
        logic [7:0] last;
        logic [3:0] reps;
        logic [1:0] fkind;   // 0 none, 1 stuck bit on read, 2 write coupling
        logic [7:0] faddr;   // stuck address or coupling victim
        logic [7:0] aggr;    // coupling aggressor
        logic       poke;    // extra start while busy
        logic       coin;    // error expected in the done cycle
        logic [7:0] errs;    // expected number of error events
    } row_t;

    localparam row_t ROWS [0:5] = '{
        '{8'd0,   8'd59,  4'd1, 2'd0, 8'd0,  8'd0,  1'b0, 1'b0, 8'd0},
        '{8'd10,  8'd73,  4'd0, 2'd0, 8'd0,  8'd0,  1'b0, 1'b0, 8'd0},
        '{8'd5,   8'd44,  4'd3, 2'd1, 8'd17, 8'd0,  1'b0, 1'b0, 8'd1},
        '{8'd0,   8'd99,  4'd2, 2'd2, 8'd40, 8'd41, 1'b0, 1'b0, 8'd1},
        '{8'd20,  8'd79,  4'd1, 2'd1, 8'd79, 8'd0,  1'b0, 1'b1, 8'd1},
        '{8'd100, 8'd140, 4'd2, 2'd0, 8'd0,  8'd0,  1'b1, 1'b0, 8'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [AW-1:0] cfg_base = '0, cfg_last = '0;
    logic [3:0] cfg_reps = '0;
    logic busy, done, mem_en, mem_we, err_valid;
    logic [AW-1:0] mem_addr, err_addr;
    logic [31:0] mem_wdata, err_exp, err_obs;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    stride_mem_tester #(
        .ADDR_W(AW),
        .REP_W (4)
    ) i_stride_mem_tester (
        .clk(clk), .rst(rst), .start(start),
        .cfg_base(cfg_base), .cfg_last(cfg_last), .cfg_reps(cfg_reps),
        .busy(busy), .done(done),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .err_valid(err_valid), .err_addr(err_addr),
        .err_exp(err_exp), .err_obs(err_obs)
    );

    // RAM model with injectable faults
    logic [31:0] mem [0:DEPTH-1];
    int          fkind = 0;
    logic [7:0]  faddr = '0, aggr = '0;
    logic [31:0] fmask = '0;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                if (fkind == 2 && mem_addr == aggr) mem[faddr] <= mem_wdata;
            end else begin
                mem_rdata <= mem[mem_addr] |
                             ((fkind == 1 && mem_addr == faddr) ? fmask : 32'h0);
            end
        end
    end

    int checks = 0, failures = 0;
    logic [31:0] pstate = SEED_M;
    logic [31:0] pat;

    int pat_cnt [0:DEPTH-1];
    int fill_cnt[0:DEPTH-1];
    int rd_cnt  [0:DEPTH-1];
    int oor, bad, ev_n, ev_mis;
    logic [7:0]  ev_addr, h1, h2;
    logic [31:0] ev_exp, ev_obs;
    logic v1, v2;
    logic [7:0] lo, hi;

    function automatic logic [31:0] model_step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ POLY_M) : (s >> 1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic sample();
        if (err_valid) begin
            ev_n++;
            if (ev_n == 1) begin
                ev_addr = err_addr; ev_exp = err_exp; ev_obs = err_obs;
            end
            if (!(v2 && h2 == err_addr)) ev_mis++;
        end
        v2 = v1; h2 = h1;
        v1 = mem_en && !mem_we; h1 = mem_addr;
        if (mem_en) begin
            if (mem_addr < lo || mem_addr > hi) oor++;
            if (mem_we) begin
                if (mem_wdata == pat) pat_cnt[mem_addr]++;
                else if (mem_wdata == ~pat) fill_cnt[mem_addr]++;
                else bad++;
            end else begin
                rd_cnt[mem_addr]++;
            end
        end
    endtask

    task automatic run_row(input row_t r, input int idx);
        int n, reps_eff, t_exp, done_cyc, lk, pbad, fbad, rbad, mbad;
        bit busy1, busy_d, err_d;
        for (int a = 0; a < DEPTH; a++) begin
            pat_cnt[a] = 0; fill_cnt[a] = 0; rd_cnt[a] = 0;
            mem[a] = 32'hC0DE_0000 | a;
        end
        oor = 0; bad = 0; ev_n = 0; ev_mis = 0; v1 = 0; v2 = 0;
        lo = r.base; hi = r.last;
        pstate = model_step(pstate);
        pat = pstate;
        fmask = '0;
        for (int b = 31; b >= 0; b--) if (!pat[b]) fmask = 32'h1 << b;
        fkind = r.fkind; faddr = r.faddr; aggr = r.aggr;
        n = r.last - r.base + 1;
        reps_eff = (r.reps == 0) ? 1 : r.reps;
        t_exp = 0;
        for (int k = 0; k < 20; k++) begin
            lk = (r.base + k <= r.last) ? ((r.last - r.base - k) / 20 + 1) : 0;
            t_exp += 2 * lk + 2 + n * reps_eff;
        end
        @(negedge clk);
        cfg_base = r.base; cfg_last = r.last; cfg_reps = r.reps; start = 1'b1;
        done_cyc = -1; busy1 = 0; busy_d = 0; err_d = 0;
        for (int c = 1; c <= RUN_LIMIT; c++) begin
            @(negedge clk);
            sample();
            start = 1'b0;
            if (c == 1) busy1 = busy;
            if (r.poke && c == 30) begin
                start = 1'b1; cfg_base = 8'd0; cfg_last = 8'd255; cfg_reps = 4'd7;
            end
            if (r.poke && c == 31) begin
                cfg_base = r.base; cfg_last = r.last; cfg_reps = r.reps;
            end
            if (done) begin
                done_cyc = c; busy_d = busy; err_d = err_valid;
                break;
            end
        end
        fkind = 0;
        pbad = 0; fbad = 0; rbad = 0; mbad = 0;
        for (int a = 0; a < DEPTH; a++) begin
            if (a >= r.base && a <= r.last) begin
                if (pat_cnt[a] != 1) pbad++;
                if (fill_cnt[a] != 19 * reps_eff) fbad++;
                if (rd_cnt[a] != 1) rbad++;
                if (((a - r.base) % 20) == 19) begin
                    if (mem[a] != pat) mbad++;
                end else if (mem[a] != ~pat) mbad++;
            end else if (mem[a] != (32'hC0DE_0000 | a)) mbad++;
        end
        check(busy1, "R2", $sformatf("row%0d busy after start", idx), busy1, 1);
        check(done_cyc == t_exp + 1, "R7", $sformatf("row%0d done cycle", idx),
              done_cyc, t_exp + 1);
        check(!busy_d, "R7", $sformatf("row%0d busy at done", idx), busy_d, 0);
        check(err_d == r.coin, "R7", $sformatf("row%0d error in done cycle", idx),
              err_d, r.coin);
        check(pbad == 0 && bad == 0, "R3", $sformatf("row%0d lane writes", idx),
              pbad + bad, 0);
        check(fbad == 0, "R4", $sformatf("row%0d inverted sweeps", idx), fbad, 0);
        check(rbad == 0, "R5", $sformatf("row%0d lane reads", idx), rbad, 0);
        check(oor == 0, "R8", $sformatf("row%0d out-of-window accesses", idx), oor, 0);
        check(mbad == 0, "R6", $sformatf("row%0d final contents", idx), mbad, 0);
        check(ev_n == r.errs && ev_mis == 0, "R5",
              $sformatf("row%0d error events", idx), ev_n, r.errs);
        if (r.errs != 0) begin
            check(ev_addr == r.faddr, "R5", $sformatf("row%0d err_addr", idx),
                  ev_addr, r.faddr);
            check(ev_exp == pat, "R5", $sformatf("row%0d err_exp", idx), ev_exp, pat);
            check(ev_obs == ((r.fkind == 1) ? (pat | fmask) : ~pat), "R5",
                  $sformatf("row%0d err_obs", idx), ev_obs,
                  (r.fkind == 1) ? (pat | fmask) : ~pat);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int acc;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !err_valid && !mem_en && !mem_we, "R1", "reset outputs",
              {busy, done, err_valid, mem_en, mem_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !mem_en, "R1", "idle after reset", {busy, mem_en}, 0);

        for (int i = 0; i < 6; i++) run_row(ROWS[i], i);

        // R9: empty window
        @(negedge clk);
        pstate = model_step(pstate);
        cfg_base = 8'd50; cfg_last = 8'd49; cfg_reps = 4'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && !busy, "R9", "empty window done", {done, busy}, 2'b10);
        acc = 0;
        for (int c = 0; c < 10; c++) begin
            if (mem_en) acc++;
            @(negedge clk);
        end
        check(acc == 0, "R9", "empty window accesses", acc, 0);

        // R1: reset mid-run returns to idle
        cfg_base = 8'd0; cfg_last = 8'd200; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!busy && !mem_en && !done, "R1", "reset during run",
              {busy, mem_en, done}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule